// File: doc/BRIEF.md
# Receive Descriptor Poll Timer

This block tells a network controller when to poll its receive descriptor ring again. It holds a 16-bit count that is extended by a seventeenth bit fixed at one. The count advances by one on every clock. When it passes its all-ones value, the block raises a poll request for one clock. At the same edge the count reloads from a programmable interval register.

Software programs the interval as the two's complement of the period it wants. The bottom four bits of the interval take no part in the reload, so the period moves in steps of 16 clocks. An interval of zero, which is also the reset value, gives the longest period of 65,536 clocks.

Both the live count and the interval are reached through a small 32-bit register port. Access is allowed only while the controller reports that it is stopped or suspended. At any other time, writes are dropped and reads return zero.

Top module: `rx_poll_timer`

## Requirements
- R1: After reset the interval register reads 0x0000 and the count reads 0x0000 (the implied top bit is not visible). An interval of zero gives 65,536 clocks between poll requests.
- R2: With interval value V, consecutive poll requests are exactly 65536 - (V & 0xFFF0) clocks apart.
- R3: Bits 3:0 of the interval have no effect on the period. They still read back as written.
- R4: poll_req_o is high for exactly one clock per expiry.
- R5: reg_sel_i = 0 selects the count and reg_sel_i = 1 selects the interval. A count write loads bits 15:0, with bit 16 implied as one. While stop_i is low, the count then increases by one per clock.
- R6: While stop_i is high the count holds its value and no poll request is made.
- R7: Registers are accessible only while stop_i or susp_i is high. Otherwise writes leave both registers unchanged and reads return zero.
- R8: Bits 31:16 always read as zero, and writing them has no effect.
- R9: Writing the interval does not disturb the running count. The new value is used from the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stop_i | input | 1 | Controller stopped: halts counting, permits register access |
| susp_i | input | 1 | Controller suspended: permits register access |
| reg_sel_i | input | 1 | Register select, 0 = count, 1 = interval |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational on select |
| poll_req_o | output | 1 | One-clock receive ring poll request |

## Verification
The hardest case to reach from the ports is a clean period measurement for a newly programmed interval. A new value only takes effect at the next reload, which can be up to 65,536 clocks away. To avoid that wait, the stimulus writes the interval while the controller is suspended and then loads the count with 0xFFFE, which forces a reload within two clocks. After that, the distance between the next two requests is exactly the programmed period. The same step puts the 65,536-clock default within the run time, and it covers an interval with nonzero low bits and one with bit 15 clear.

// File: rtl/rxp_pkg.sv
package rxp_pkg;
  typedef enum logic {
    RXP_SEL_CNT  = 1'b0,
    RXP_SEL_IVAL = 1'b1
  } rxp_sel_e;
endpackage

// File: rtl/rxp_regacc.sv
module rxp_regacc
  import rxp_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int BUS_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_i,
  input  logic             susp_i,
  input  logic             reg_sel_i,
  input  logic             reg_we_i,
  input  logic [BUS_W-1:0] reg_wdata_i,
  input  logic [CNT_W-1:0] cnt_val_i,
  output logic [CNT_W-1:0] ival_o,
  output logic             cnt_wr_o,
  output logic [CNT_W-1:0] cnt_wdata_o,
  output logic [BUS_W-1:0] reg_rdata_o
);
  localparam int PAD_W = BUS_W - CNT_W;

  logic             acc_ok;
  logic             ival_wr;
  logic [CNT_W-1:0] sel_val;
  logic             unused_hi;

  assign acc_ok      = stop_i | susp_i;
  assign ival_wr     = acc_ok & reg_we_i & (rxp_sel_e'(reg_sel_i) == RXP_SEL_IVAL);
  assign cnt_wr_o    = acc_ok & reg_we_i & (rxp_sel_e'(reg_sel_i) == RXP_SEL_CNT);
  assign cnt_wdata_o = reg_wdata_i[CNT_W-1:0];
  assign unused_hi   = ^reg_wdata_i[BUS_W-1:CNT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ival_o <= '0;
    else if (ival_wr) ival_o <= reg_wdata_i[CNT_W-1:0];
  end

  assign sel_val     = (rxp_sel_e'(reg_sel_i) == RXP_SEL_IVAL) ? ival_o : cnt_val_i;
  assign reg_rdata_o = acc_ok ? {{PAD_W{1'b0}}, sel_val} : '0;

  // R7
  ival_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_i && !susp_i && reg_we_i) |=> $stable(ival_o));

  // R8
  rdata_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata_o[BUS_W-1:CNT_W] == '0);
endmodule

// File: rtl/rxp_counter.sv
module rxp_counter #(
  parameter int CNT_W = 16,
  parameter int IGN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [CNT_W-1:0] ival_i,
  input  logic             cnt_wr_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             poll_o
);
  localparam int FULL_W = CNT_W + 1;

  function automatic logic [FULL_W-1:0] reload_of(input logic [CNT_W-1:0] iv);
    return {1'b1, iv[CNT_W-1:IGN_W], {IGN_W{1'b0}}};
  endfunction

  logic [FULL_W-1:0] cnt_q;
  logic              at_end;
  logic              wrap_evt;
  logic              unused_lo;

  assign at_end    = &cnt_q;
  assign wrap_evt  = run_i & at_end & ~cnt_wr_i;
  assign unused_lo = ^ival_i[IGN_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= {1'b1, {CNT_W{1'b0}}};
    else if (cnt_wr_i)  cnt_q <= {1'b1, cnt_wdata_i};
    else if (wrap_evt)  cnt_q <= reload_of(ival_i);
    else if (run_i)     cnt_q <= cnt_q + FULL_W'(1);
  end

  assign cnt_o  = cnt_q[CNT_W-1:0];
  assign poll_o = wrap_evt;

  // R4
  poll_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    poll_o |=> !poll_o);

  // R3
  reload_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    poll_o |=> (cnt_q[IGN_W-1:0] == '0));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !cnt_wr_i) |=> $stable(cnt_q));

  // R5
  top_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q[CNT_W]);

  // R9
  ival_nodisturb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(ival_i) && run_i && !at_end && !cnt_wr_i) |=> (cnt_q == $past(cnt_q) + FULL_W'(1)));
endmodule

// File: rtl/rx_poll_timer.sv
module rx_poll_timer #(
  parameter int CNT_W = 16,
  parameter int IGN_W = 4,
  parameter int BUS_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_i,
  input  logic             susp_i,
  input  logic             reg_sel_i,
  input  logic             reg_we_i,
  input  logic [BUS_W-1:0] reg_wdata_i,
  output logic [BUS_W-1:0] reg_rdata_o,
  output logic             poll_req_o
);
  logic [CNT_W-1:0] ival;
  logic [CNT_W-1:0] cnt_val;
  logic [CNT_W-1:0] cnt_wdata;
  logic             cnt_wr;

  rxp_regacc #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_regacc (
    .clk         (clk),
    .rst_n       (rst_n),
    .stop_i      (stop_i),
    .susp_i      (susp_i),
    .reg_sel_i   (reg_sel_i),
    .reg_we_i    (reg_we_i),
    .reg_wdata_i (reg_wdata_i),
    .cnt_val_i   (cnt_val),
    .ival_o      (ival),
    .cnt_wr_o    (cnt_wr),
    .cnt_wdata_o (cnt_wdata),
    .reg_rdata_o (reg_rdata_o)
  );

  rxp_counter #(.CNT_W(CNT_W), .IGN_W(IGN_W)) u_counter (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_i       (~stop_i),
    .ival_i      (ival),
    .cnt_wr_i    (cnt_wr),
    .cnt_wdata_i (cnt_wdata),
    .cnt_o       (cnt_val),
    .poll_o      (poll_req_o)
  );

  // R6
  stop_nopoll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |-> !poll_req_o);
endmodule

// File: tb/test_rx_poll_timer.sv
`timescale 1ns/1ps
module test_rx_poll_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stop_i = 1'b1;
  logic        susp_i = 1'b0;
  logic        reg_sel_i = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        poll_req_o;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  localparam int NVEC = 5;
  localparam logic [15:0] VEC_IV [NVEC] = '{16'hFFF0, 16'hFFFF, 16'hFF00, 16'hFFE7, 16'h7FF0};
  localparam int          VEC_P  [NVEC] = '{16, 16, 256, 32, 32784};

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rx_poll_timer i_rx_poll_timer (
    .clk(clk), .rst_n(rst_n), .stop_i(stop_i), .susp_i(susp_i),
    .reg_sel_i(reg_sel_i), .reg_we_i(reg_we_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .poll_req_o(poll_req_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic s, input logic [31:0] d);
    @(negedge clk);
    reg_sel_i = s; reg_wdata_i = d; reg_we_i = 1'b1;
    @(negedge clk);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic s, output logic [31:0] v);
    @(negedge clk);
    reg_sel_i = s; reg_we_i = 1'b0;
    #1 v = reg_rdata_o;
  endtask

  task automatic wait_poll(output int c);
    @(negedge clk);
    while (!poll_req_o) @(negedge clk);
    c = cyc;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int a, b, npoll;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(1'b1, v); check("R1 ival reset", v, 32'h0);
    rd(1'b0, v); check("R1 count reset", v, 32'h0);

    // R5 count write and increment
    wr(1'b0, 32'h0000_1234);
    rd(1'b0, v); check("R5 count write", v, 32'h1234);
    @(negedge clk); stop_i = 1'b0;
    repeat (10) @(negedge clk);
    stop_i = 1'b1;
    rd(1'b0, v); check("R5 count step", v, 32'h123E);

    // R8 upper bits
    wr(1'b1, 32'hABCD_FFF0);
    rd(1'b1, v); check("R8 upper zero", v, 32'h0000_FFF0);

    // R9 interval write leaves count alone
    rd(1'b0, v); check("R9 count kept", v, 32'h123E);

    // R7 access gating
    @(negedge clk); stop_i = 1'b0; susp_i = 1'b0;
    wr(1'b1, 32'h0000_1110);
    rd(1'b1, v); check("R7 read gated", v, 32'h0);
    susp_i = 1'b1;
    rd(1'b1, v); check("R7 write ignored", v, 32'h0000_FFF0);

    // R6 stop holds count, no poll
    @(negedge clk); stop_i = 1'b1; susp_i = 1'b0;
    wr(1'b0, 32'h0000_FFF8);
    npoll = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (poll_req_o) npoll++;
    end
    check("R6 no poll", npoll, 0);
    rd(1'b0, v); check("R6 count held", v, 32'h0000_FFF8);

    // R1 default period
    wr(1'b1, 32'h0);
    wr(1'b0, 32'h0000_FFFE);
    @(negedge clk); stop_i = 1'b0; susp_i = 1'b1;
    wait_poll(a);
    @(negedge clk); check("R4 single cycle", poll_req_o, 1'b0);
    wait_poll(b);
    check("R1 default period", b - a, 65536);

    // R2 / R3 table of programmed intervals
    for (int k = 0; k < NVEC; k++) begin
      wr(1'b1, {16'h0, VEC_IV[k]});
      wr(1'b0, 32'h0000_FFFE);
      wait_poll(a);
      wait_poll(b);
      if (VEC_IV[k][3:0] != 4'h0) check("R3 low bits masked", b - a, VEC_P[k]);
      else                        check("R2 period", b - a, VEC_P[k]);
    end
    rd(1'b1, v); check("R3 low bits readback", v, 32'h0000_7FF0);

    finish_run();
  end
endmodule